// File: doc/BRIEF.md
# Indirect Register Command Bridge for a Two-Wire Serial Controller

This block lets software reach the byte-wide internal registers of a two-wire serial controller through one 64-bit command word. Software writes the word with a start flag, a direction flag, a primary selector, a secondary selector and a data byte. The bridge decodes the word and performs exactly one register access on the controller's internal bus. When that access ends, the bridge drops the start flag. For a read, it also places the fetched byte in the low byte of the word. Software polls the word until the start flag reads 0.

The controller side is a small behavioural register file. It holds clock, data, control and clock-control registers and a status register that reads back the idle code. It answers each request after a fixed latency. A reset selector returns its registers to their reset values.

Top module: `csr_cmd_bridge`

## Requirements
- R1: A write to the command word whose bit 63 is 0 is stored as written and starts no register access; the stored word then stays unchanged while no further write arrives.
- R2: A write with bit 63 set starts one access; bit 63 reads back as 1 for exactly ACC_LAT+1 clock cycles after the accepting edge (3 with the default ACC_LAT of 2) and then reads 0.
- R3: The primary selector in bits 60:57 equal to 4 addresses the clock register; a write stores bits 7:0 there and a read returns it.
- R4: The primary selector equal to 6 uses the secondary selector in bits 34:32; value 1 addresses the data register and value 2 the control register, both readable and writable.
- R5: Secondary selector 3 writes the clock-control register, but a read with it returns the status register, which holds 0xF8 and is not changed by such a write.
- R6: Bit 56 set marks a read. On completion of a read, bits 7:0 carry the fetched byte. On completion of a write, bits 7:0 keep the written value. In both cases only bit 63 and, for a read, bits 7:0 change.
- R7: Secondary selector 7 resets the controller's clock, data, control and clock-control registers to 0x00.
- R8: A primary selector other than 4 or 6, or a secondary selector of 0, 4, 5 or 6, completes normally with no register effect, and a read of it returns 0x00.
- R9: A write to the command word is ignored in any cycle where bit 63 reads 1, including the cycle in which the access completes; a write in the next cycle is accepted.
- R10: After reset the command word reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_we | input | 1 | Write strobe for the command word |
| cmd_wdata | input | 64 | Value written to the command word |
| cmd_rdata | output | 64 | Current command word |

## Verification
A software write and access completion can land on the same clock edge. At that edge, bit 63 still reads 1 and the bridge is clearing it and merging the read byte. The bench holds the write strobe high with a second command from the cycle after acceptance through the completion edge. At the completion edge, it checks that the first command's result is intact and that the second command has not been taken. On the following edge, it checks that the held command is accepted and later returns the byte the first command wrote.

// File: rtl/twsi_bridge_pkg.sv
package twsi_bridge_pkg;
    localparam int CMD_W      = 64;
    localparam int BYTE_W     = 8;
    localparam int VALID_BIT  = 63;
    localparam int READ_BIT   = 56;
    localparam int OP_LSB     = 57;
    localparam int OP_W       = 4;
    localparam int EXT_LSB    = 32;
    localparam int EXT_W      = 3;

    localparam logic [OP_W-1:0]  OP_CLOCK   = 4'd4;
    localparam logic [OP_W-1:0]  OP_EXTEND  = 4'd6;
    localparam logic [EXT_W-1:0] EXT_DATA   = 3'd1;
    localparam logic [EXT_W-1:0] EXT_CTRL   = 3'd2;
    localparam logic [EXT_W-1:0] EXT_CKSTAT = 3'd3;
    localparam logic [EXT_W-1:0] EXT_RESET  = 3'd7;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CLOCK,
        SEL_DATA,
        SEL_CTRL,
        SEL_CLKCTL,
        SEL_STATUS,
        SEL_RESET
    } reg_sel_e;

    typedef struct packed {
        logic              vld;
        reg_sel_e          sel;
        logic              rd;
        logic [BYTE_W-1:0] wd;
    } acc_req_t;
endpackage

// File: rtl/twsi_cmd_decode.sv
module twsi_cmd_decode
    import twsi_bridge_pkg::*;
(
    input  logic [OP_W-1:0]  op,
    input  logic [EXT_W-1:0] ext,
    input  logic             rd,
    output reg_sel_e         sel
);
    always_comb begin
        sel = SEL_NONE;
        if (op == OP_CLOCK) begin
            sel = SEL_CLOCK;
        end else if (op == OP_EXTEND) begin
            unique case (ext)
                EXT_DATA:   sel = SEL_DATA;
                EXT_CTRL:   sel = SEL_CTRL;
                EXT_CKSTAT: sel = rd ? SEL_STATUS : SEL_CLKCTL;
                EXT_RESET:  sel = SEL_RESET;
                default:    sel = SEL_NONE;
            endcase
        end
    end
endmodule

// File: rtl/twsi_reg_model.sv
module twsi_reg_model
    import twsi_bridge_pkg::*;
#(
    parameter int                ACC_LAT   = 2,
    parameter logic [BYTE_W-1:0] IDLE_CODE = 8'hF8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  acc_req_t          req,
    output logic              ack,
    output logic [BYTE_W-1:0] rdata
);
    localparam int STAGES = (ACC_LAT < 2) ? 1 : ACC_LAT - 1;

    typedef struct packed {
        acc_req_t [STAGES-1:0] pipe;
        logic [BYTE_W-1:0]     clock_r;
        logic [BYTE_W-1:0]     data_r;
        logic [BYTE_W-1:0]     ctrl_r;
        logic [BYTE_W-1:0]     clkctl_r;
        logic                  ack;
        logic [BYTE_W-1:0]     rdata;
    } model_st_t;

    model_st_t st_d, st_q;
    acc_req_t  head;

    always_comb begin
        st_d         = st_q;
        st_d.pipe[0] = req;
        for (int i = 1; i < STAGES; i++) begin
            st_d.pipe[i] = st_q.pipe[i-1];
        end
        head       = st_q.pipe[STAGES-1];
        st_d.ack   = head.vld;
        st_d.rdata = '0;
        if (head.vld) begin
            unique case (head.sel)
                SEL_CLOCK: begin
                    if (head.rd) st_d.rdata   = st_q.clock_r;
                    else         st_d.clock_r = head.wd;
                end
                SEL_DATA: begin
                    if (head.rd) st_d.rdata  = st_q.data_r;
                    else         st_d.data_r = head.wd;
                end
                SEL_CTRL: begin
                    if (head.rd) st_d.rdata  = st_q.ctrl_r;
                    else         st_d.ctrl_r = head.wd;
                end
                SEL_CLKCTL: st_d.clkctl_r = head.wd;
                SEL_STATUS: st_d.rdata    = IDLE_CODE;
                SEL_RESET: begin
                    st_d.clock_r  = '0;
                    st_d.data_r   = '0;
                    st_d.ctrl_r   = '0;
                    st_d.clkctl_r = '0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ack   = st_q.ack;
    assign rdata = st_q.rdata;
endmodule

// File: rtl/csr_cmd_bridge.sv
module csr_cmd_bridge
    import twsi_bridge_pkg::*;
#(
    parameter int ACC_LAT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_we,
    input  logic [CMD_W-1:0] cmd_wdata,
    output logic [CMD_W-1:0] cmd_rdata
);
    typedef struct packed {
        logic [CMD_W-1:0] word;
        logic             issued;
    } br_st_t;

    br_st_t            br_d, br_q;
    reg_sel_e          dec_sel;
    acc_req_t          acc_req_s;
    logic              acc_req;
    logic              acc_ack;
    logic [BYTE_W-1:0] acc_rdata;

    twsi_cmd_decode u_decode (
        .op  (br_q.word[OP_LSB +: OP_W]),
        .ext (br_q.word[EXT_LSB +: EXT_W]),
        .rd  (br_q.word[READ_BIT]),
        .sel (dec_sel)
    );

    always_comb begin
        br_d    = br_q;
        acc_req = 1'b0;
        if (!br_q.word[VALID_BIT]) begin
            br_d.issued = 1'b0;
            if (cmd_we) br_d.word = cmd_wdata;
        end else begin
            if (!br_q.issued) begin
                acc_req     = 1'b1;
                br_d.issued = 1'b1;
            end
            if (acc_ack) begin
                br_d.word[VALID_BIT] = 1'b0;
                br_d.issued          = 1'b0;
                if (br_q.word[READ_BIT]) br_d.word[BYTE_W-1:0] = acc_rdata;
            end
        end
    end

    always_comb begin
        acc_req_s.vld = acc_req;
        acc_req_s.sel = dec_sel;
        acc_req_s.rd  = br_q.word[READ_BIT];
        acc_req_s.wd  = br_q.word[BYTE_W-1:0];
    end

    twsi_reg_model #(.ACC_LAT(ACC_LAT)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (acc_req_s),
        .ack   (acc_ack),
        .rdata (acc_rdata)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) br_q <= '0;
        else        br_q <= br_d;
    end

    assign cmd_rdata = br_q.word;
endmodule

// File: rtl/csr_bridge_chk.sv
module csr_bridge_chk #(
    parameter int ACC_LAT = 2
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_we,
    input logic [63:0] word,
    input logic        acc_req,
    input logic        acc_ack
);
    logic [7:0] busy_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       busy_cnt <= '0;
        else if (word[63]) busy_cnt <= busy_cnt + 8'd1;
        else              busy_cnt <= '0;
    end

    AST_IDLE_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!word[63] && !cmd_we) |=> $stable(word)); // R1

    AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(word[63]) |-> (busy_cnt == 8'(ACC_LAT + 1))); // R2

    AST_SINGLE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        acc_req |=> !acc_req); // R2

    AST_ACK_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        acc_ack |-> word[63]); // R2

    AST_WRITE_BYTE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(word[63]) && !word[56]) |-> $stable(word[7:0])); // R6

    AST_BUSY_IGNORES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        word[63] |=> $stable(word[62:8])); // R9
endmodule

bind csr_cmd_bridge csr_bridge_chk #(.ACC_LAT(ACC_LAT)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd_we  (cmd_we),
    .word    (cmd_rdata),
    .acc_req (acc_req),
    .acc_ack (acc_ack)
);

// File: tb/tb_csr_cmd_bridge.sv
`timescale 1ns/1ps
module tb_csr_cmd_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_we = 1'b0;
    logic [63:0] cmd_wdata = '0;
    logic [63:0] cmd_rdata;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    bit done = 1'b0;

    csr_cmd_bridge dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_we    (cmd_we),
        .cmd_wdata (cmd_wdata),
        .cmd_rdata (cmd_rdata)
    );

    always #2.5 clk = ~clk;

    function automatic logic [63:0] mk(input bit rd, input logic [3:0] op,
                                       input logic [2:0] ext, input logic [7:0] d);
        logic [63:0] w;
        w        = '0;
        w[63]    = 1'b1;
        w[56]    = rd;
        w[60:57] = op;
        w[34:32] = ext;
        w[7:0]   = d;
        return w;
    endfunction

    // entry: {requirement number, command word, expected read byte}
    localparam int NV = 18;
    localparam logic [79:0] VEC [NV] = '{
        {8'd3,  mk(0, 4'd4, 3'd0, 8'h5A), 8'h00}, // R3 write clock
        {8'd3,  mk(1, 4'd4, 3'd0, 8'h00), 8'h5A}, // R3 read clock
        {8'd4,  mk(0, 4'd6, 3'd1, 8'h3C), 8'h00}, // R4 write data
        {8'd4,  mk(0, 4'd6, 3'd2, 8'h44), 8'h00}, // R4 write control
        {8'd6,  mk(1, 4'd6, 3'd1, 8'hFF), 8'h3C}, // R6 read data over stale byte
        {8'd4,  mk(1, 4'd6, 3'd2, 8'h00), 8'h44}, // R4 read control
        {8'd5,  mk(0, 4'd6, 3'd3, 8'h13), 8'h00}, // R5 write clock-control
        {8'd5,  mk(1, 4'd6, 3'd3, 8'h00), 8'hF8}, // R5 read gives status
        {8'd8,  mk(1, 4'd5, 3'd1, 8'hAA), 8'h00}, // R8 unlisted opcode read
        {8'd8,  mk(0, 4'd2, 3'd0, 8'h77), 8'h00}, // R8 unlisted opcode write
        {8'd8,  mk(1, 4'd4, 3'd0, 8'h00), 8'h5A}, // R8 clock untouched
        {8'd8,  mk(1, 4'd6, 3'd5, 8'h66), 8'h00}, // R8 unlisted ext read
        {8'd8,  mk(0, 4'd6, 3'd4, 8'h11), 8'h00}, // R8 unlisted ext write
        {8'd8,  mk(1, 4'd6, 3'd1, 8'h00), 8'h3C}, // R8 data untouched
        {8'd7,  mk(0, 4'd6, 3'd7, 8'h00), 8'h00}, // R7 controller reset
        {8'd7,  mk(1, 4'd4, 3'd0, 8'hEE), 8'h00}, // R7 clock cleared
        {8'd7,  mk(1, 4'd6, 3'd1, 8'hEE), 8'h00}, // R7 data cleared
        {8'd7,  mk(1, 4'd6, 3'd2, 8'hEE), 8'h00}  // R7 control cleared
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [63:0] w);
        @(negedge clk);
        cmd_we    = 1'b1;
        cmd_wdata = w;
        @(posedge clk);
        @(negedge clk);
        cmd_we    = 1'b0;
    endtask

    function automatic logic [63:0] result(input logic [63:0] w, input logic [7:0] b);
        logic [63:0] e;
        e     = w;
        e[63] = 1'b0;
        if (w[56]) e[7:0] = b;
        return e;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d cycles expected=<100000", cycles);
            finish_run();
        end
    end

    initial begin
        logic [63:0] a;
        logic [63:0] b;
        int hi;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 reset word", cmd_rdata, 64'h0);

        // R2: count cycles with bit 63 set
        issue(mk(0, 4'd6, 3'd2, 8'h01));
        hi = 0;
        for (int k = 0; k < 6; k++) begin
            if (cmd_rdata[63]) hi++;
            @(negedge clk);
        end
        check("R2 busy cycles", 64'(hi), 64'd3);

        // table of commands
        for (int i = 0; i < NV; i++) begin
            issue(VEC[i][71:8]);
            repeat (3) @(posedge clk);
            @(negedge clk);
            check($sformatf("R%0d vector %0d", VEC[i][79:72], i),
                  cmd_rdata, result(VEC[i][71:8], VEC[i][7:0]));
        end

        // R1: word with bit 63 clear is stored and starts nothing
        a = mk(0, 4'd4, 3'd0, 8'h99);
        a[63] = 1'b0;
        issue(a);
        check("R1 stored word", cmd_rdata, a);
        repeat (5) @(negedge clk);
        check("R1 word held", cmd_rdata, a);
        issue(mk(1, 4'd4, 3'd0, 8'h00));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 no clock write", {56'h0, cmd_rdata[7:0]}, 64'h0);

        // R9: write held through busy and completion edge
        a = mk(0, 4'd6, 3'd1, 8'h21);
        b = mk(1, 4'd6, 3'd1, 8'h00);
        issue(a);
        cmd_we    = 1'b1;
        cmd_wdata = b;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R9 completion edge ignores write", cmd_rdata, result(a, 8'h00));
        @(posedge clk);
        @(negedge clk);
        cmd_we = 1'b0;
        check("R9 next write accepted", cmd_rdata, b);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R9 held command result", cmd_rdata, result(b, 8'h21));

        // R6: write completion keeps low byte
        a = mk(0, 4'd6, 3'd2, 8'hC3);
        issue(a);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R6 write keeps byte", cmd_rdata, result(a, 8'h00));

        finish_run();
    end
endmodule